// File: doc/BRIEF.md
# Interrupt Control Register with Port-Change Detect

This block is the interrupt control and status register of a small 8-bit microcontroller core. It is one byte on the core's register bus. Five bits are enables: a global enable, an enable for the peripheral group, and one enable for each of three local sources. Three bits are event flags for those local sources. The local sources are a timer overflow pulse, a rising edge on an asynchronous external pin, and a change on the upper four bits of an input port. The block drives a single interrupt request into the core.

A flag latches its event whether or not the event is enabled, and only a bus write can clear it. The port-change flag works against a copy of the upper port nibble. The copy is refreshed only when the core reads the port through this block's port address. While the port differs from that copy, the flag keeps setting itself again, so firmware has to read the port before the clear takes effect. The register decodes the low seven address bits only, so it appears at four mirrored addresses on the 9-bit bus.

Top module: `intr_ctrl_reg`

## Requirements
- R1: The register byte holds, from bit 7 down to bit 0: global enable, peripheral enable, timer enable, external-pin enable, port-change enable, timer flag, external-pin flag, port-change flag. A write loads all eight bits from `bus_wdata`.
- R2: Each flag sets on its event even when its own enable, the peripheral enable and the global enable are 0.
- R3: Hardware never clears a flag. A flag changes only through a bus write of the register, and it takes the written bit value.
- R4: At every clock edge where `port_in[7:4]` differs from the latched copy, the port-change flag is set. Changes on `port_in[3:0]` have no effect on it.
- R5: A read (`bus_rd`=1) at the port address (low seven address bits 0x06) returns `port_in` on `bus_rdata` and loads `port_in[7:4]` into the copy at that edge. Once the copy matches, a written 0 clears the port-change flag.
- R6: `irq` = global enable AND (any local flag whose enable is 1 OR peripheral enable AND `periph_req`). It is combinational from the register and `periph_req`. With the global enable at 0, `irq` is 0.
- R7: The register responds when the low seven address bits equal 0x0B, that is at 0x00B, 0x08B, 0x10B and 0x18B. Writes to any other address leave it unchanged, and reads there that hit neither the register nor the port return 0.
- R8: Reset (`rst_n`=0) clears bits 7 to 1 of the register. The reset value of bit 0 is not specified to software.
- R9: With the peripheral enable at 0, `periph_req` cannot raise `irq`.
- R10: When a flag's event and a bus write of 0 to that flag occur at the same edge, the flag ends up set.
- R11: `ext_pin` passes through a two-flop synchronizer. A 0-to-1 change sampled at edge k sets the external-pin flag at edge k+2. A falling change sets nothing.
- R12: A one-cycle `tmr_ovf` pulse sets the timer flag at the next edge.
- R13: `bus_rdata` follows the address combinationally. A register read has no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 9 | Register bus address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effect on port reads only) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| tmr_ovf | input | 1 | Timer overflow pulse |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| port_in | input | 8 | Input port value |
| periph_req | input | 1 | Combined peripheral-group request |
| irq | output | 1 | Interrupt request to the core |

## Verification
Two things can act on the same flag at the same edge: a hardware event that sets it and a software write that clears it. The bench forces this in three ways. It sends a timer pulse in the same cycle as a write of 0. It writes 0 to the port-change flag while the port still differs from the latched copy. It runs a long stretch of random bus traffic that overlaps with pin toggles and port changes. The outcome is judged by reading the register back in the next cycle, where the flag must still be set. It is also judged every cycle against a behavioural model, in which the event takes priority over the write.

// File: rtl/intc_pkg.sv
package intc_pkg;
   // Source indices; each index is also the flag bit and (index+3) the enable bit
   localparam int NUM_SRC     = 3;
   localparam int SRC_PORT    = 0;
   localparam int SRC_EXT     = 1;
   localparam int SRC_TMR     = 2;
   localparam int BIT_FLAG_LO = 0;
   localparam int BIT_EN_LO   = BIT_FLAG_LO + NUM_SRC;
   localparam int BIT_PEIE    = BIT_EN_LO + NUM_SRC;
   localparam int BIT_GIE     = BIT_PEIE + 1;
   localparam int REG_BITS    = BIT_GIE + 1;

   typedef struct packed {
      logic                gie;
      logic                peie;
      logic [NUM_SRC-1:0]  en;
   } intc_ctrl_t;
endpackage

// File: rtl/intc_sync_edge.sv
module intc_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic rise
);
   initial begin
      assert (STAGES >= 2) else $error("intc_sync_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sync_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], pin};
         last_q <= sync_q[STAGES-1];
      end
   end

   assign rise = sync_q[STAGES-1] & ~last_q;

   // R11
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
endmodule

// File: rtl/intc_port_watch.sv
module intc_port_watch #(
   parameter int PORT_W = 8,
   parameter int CHG_LO = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PORT_W-1:0] port,
   input  logic              relatch,
   output logic              mismatch
);
   localparam int WATCH_W = PORT_W - CHG_LO;

   initial begin
      assert (CHG_LO >= 0 && CHG_LO < PORT_W) else $error("intc_port_watch: bad CHG_LO");
   end

   logic [WATCH_W-1:0] copy_q;
   logic [WATCH_W-1:0] watched;
   logic [CHG_LO-1:0]  unused_low;

   assign watched    = port[PORT_W-1:CHG_LO];
   assign unused_low = port[CHG_LO-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       copy_q <= '0;
      else if (relatch) copy_q <= watched;
   end

   assign mismatch = (watched != copy_q);

   // R5
   relatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      relatch |=> (copy_q == $past(watched)));
endmodule

// File: rtl/intc_flag_cell.sv
module intc_flag_cell #(
   parameter logic RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hw_set,
   input  logic sw_wr,
   input  logic sw_val,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag <= RESET_VAL;
      else if (hw_set) flag <= 1'b1;
      else if (sw_wr)  flag <= sw_val;
   end

   // R10
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hw_set |=> flag);

   // R3
   sw_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_wr && !hw_set) |=> (flag == $past(sw_val)));

   // R3
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw_wr && !hw_set) |=> $stable(flag));
endmodule

// File: rtl/intr_ctrl_reg.sv
module intr_ctrl_reg
   import intc_pkg::*;
#(
   parameter int          ADDR_W         = 9,
   parameter int          DATA_W         = 8,
   parameter int          PORT_W         = 8,
   parameter int          CHG_LO         = 4,
   parameter int          DEC_W          = 7,
   parameter logic [6:0]  REG_ADDR       = 7'h0B,
   parameter logic [6:0]  PORT_ADDR      = 7'h06,
   parameter int          SYNC_STAGES    = 2,
   parameter bit          IRQ_REGISTERED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              tmr_ovf,
   input  logic              ext_pin,
   input  logic [PORT_W-1:0] port_in,
   input  logic              periph_req,
   output logic              irq
);
   localparam int MIRROR_W = ADDR_W - DEC_W;

   initial begin
      assert (DATA_W == REG_BITS) else $error("intr_ctrl_reg: DATA_W must match register layout");
      assert (PORT_W == DATA_W)   else $error("intr_ctrl_reg: port must fit the data bus");
      assert (DEC_W == 7 && MIRROR_W >= 1) else $error("intr_ctrl_reg: bad decode width");
   end

   // ---------------- address decode ----------------
   logic [DEC_W-1:0]    dec_addr;
   logic [MIRROR_W-1:0] unused_mirror;
   logic                reg_hit, port_hit, wr_reg, rd_port;

   assign dec_addr      = bus_addr[DEC_W-1:0];
   assign unused_mirror = bus_addr[ADDR_W-1:DEC_W];
   assign reg_hit       = (dec_addr == REG_ADDR);
   assign port_hit      = (dec_addr == PORT_ADDR);
   assign wr_reg        = bus_wr & reg_hit;
   assign rd_port       = bus_rd & port_hit;

   // ---------------- enable bits ----------------
   intc_ctrl_t ctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_reg) begin
         ctrl_q.gie  <= bus_wdata[BIT_GIE];
         ctrl_q.peie <= bus_wdata[BIT_PEIE];
         ctrl_q.en   <= bus_wdata[BIT_EN_LO +: NUM_SRC];
      end
   end

   // ---------------- event sources ----------------
   logic ext_rise, port_mismatch;

   intc_sync_edge #(.STAGES(SYNC_STAGES)) u_ext_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (ext_pin),
      .rise (ext_rise)
   );

   intc_port_watch #(.PORT_W(PORT_W), .CHG_LO(CHG_LO)) u_port_watch (
      .clk     (clk),
      .rst_n   (rst_n),
      .port    (port_in),
      .relatch (rd_port),
      .mismatch(port_mismatch)
   );

   logic [NUM_SRC-1:0] hw_set;
   logic [NUM_SRC-1:0] flag_q;

   always_comb begin
      hw_set           = '0;
      hw_set[SRC_PORT] = port_mismatch;
      hw_set[SRC_EXT]  = ext_rise;
      hw_set[SRC_TMR]  = tmr_ovf;
   end

   // ---------------- flag bank ----------------
   for (genvar g = 0; g < NUM_SRC; g++) begin : g_flag
      intc_flag_cell #(.RESET_VAL(1'b0)) u_cell (
         .clk   (clk),
         .rst_n (rst_n),
         .hw_set(hw_set[g]),
         .sw_wr (wr_reg),
         .sw_val(bus_wdata[BIT_FLAG_LO + g]),
         .flag  (flag_q[g])
      );
   end

   // ---------------- read path ----------------
   logic [DATA_W-1:0] reg_val;
   assign reg_val = {ctrl_q.gie, ctrl_q.peie, ctrl_q.en, flag_q};

   always_comb begin
      if (reg_hit)       bus_rdata = reg_val;
      else if (port_hit) bus_rdata = port_in;
      else               bus_rdata = '0;
   end

   // ---------------- request output ----------------
   logic irq_d;
   assign irq_d = ctrl_q.gie & ((|(ctrl_q.en & flag_q)) | (ctrl_q.peie & periph_req));

   if (IRQ_REGISTERED) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_d;
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = irq_d;

      // R6
      gie_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !ctrl_q.gie |-> !irq);

      // R9
      periph_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!ctrl_q.peie && ((ctrl_q.en & flag_q) == '0)) |-> !irq);
   end

   // R7
   ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !reg_hit) |=> $stable(ctrl_q));

   // R12
   tmr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_ovf |=> flag_q[SRC_TMR]);
endmodule

// File: tb/test_intr_ctrl_reg.sv
module test_intr_ctrl_reg;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [8:0] bus_addr;
   logic       bus_wr, bus_rd;
   logic [7:0] bus_wdata, bus_rdata;
   logic       tmr_ovf, ext_pin, periph_req, irq;
   logic [7:0] port_in;

   always #10 clk = ~clk;

   intr_ctrl_reg i_intr_ctrl_reg (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_ovf(tmr_ovf), .ext_pin(ext_pin),
      .port_in(port_in), .periph_req(periph_req), .irq(irq)
   );

   int    checks = 0;
   int    errors = 0;
   string phase  = "R8";
   logic  pin_v = 1'b0, preq_v = 1'b0;
   logic [7:0] port_v = 8'h00;
   logic [7:0] last_rd;

   // ---------------- behavioural reference ----------------
   bit   m_gie, m_peie, m_ten, m_xen, m_pen, m_tf, m_xf, m_pf, p_known;
   bit [3:0] m_copy;
   bit   pin_hist[$];

   always @(posedge clk) begin
      if (!rst_n) begin
         {m_gie, m_peie, m_ten, m_xen, m_pen, m_tf, m_xf, m_pf} = '0;
         p_known = 0; m_copy = 0;
         pin_hist = {1'b0, 1'b0, 1'b0, 1'b0};
      end else begin
         bit wr, mism, xset;
         wr   = bus_wr && (bus_addr[6:0] == 7'h0B);
         mism = (port_in[7:4] != m_copy);
         pin_hist.push_front(ext_pin);
         xset = pin_hist[2] && !pin_hist[3];
         void'(pin_hist.pop_back());
         if (wr) begin
            {m_gie, m_peie, m_ten, m_xen, m_pen, m_tf, m_xf, m_pf} = bus_wdata;
            p_known = 1;
         end
         if (tmr_ovf) m_tf = 1;
         if (xset)    m_xf = 1;
         if (mism)    m_pf = 1;
         if (bus_rd && bus_addr[6:0] == 7'h06) m_copy = port_in[7:4];
      end
   end

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare();
      logic [7:0] er, mask;
      logic       ei;
      mask = 8'hFF;
      if (bus_addr[6:0] == 7'h0B) begin
         er = {m_gie, m_peie, m_ten, m_xen, m_pen, m_tf, m_xf, m_pf};
         if (!p_known) mask = 8'hFE;
      end else if (bus_addr[6:0] == 7'h06) er = port_in;
      else er = 8'h00;
      ei = m_gie && ((m_ten && m_tf) || (m_xen && m_xf) || (m_pen && m_pf && p_known)
                     || (m_peie && periph_req));
      check({phase, " rdata"}, bus_rdata & mask, er & mask);
      check({phase, " irq"}, {7'd0, irq}, {7'd0, ei});
   endtask

   // one bus cycle, starting and ending at a falling edge
   task automatic cyc(input logic [8:0] a, input logic w, input logic r,
                      input logic [7:0] d, input logic t);
      bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d; tmr_ovf = t;
      ext_pin = pin_v; port_in = port_v; periph_req = preq_v;
      #5;
      compare();
      last_rd = bus_rdata;
      @(negedge clk);
      bus_wr = 0; bus_rd = 0; tmr_ovf = 0;
   endtask

   task automatic peek(input logic [7:0] exp, input logic [7:0] mask, input string tag);
      cyc(9'h00B, 0, 1, 8'h00, 0);
      check(tag, last_rd & mask, exp & mask);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(9'h000, 0, 0, 8'h00, 0);
   endtask

   function automatic logic [8:0] pick_addr(input int s);
      case (s)
         0: return 9'h00B; 1: return 9'h08B; 2: return 9'h10B; 3: return 9'h18B;
         4: return 9'h006; 5: return 9'h186; 6: return 9'h00C; default: return 9'h02B;
      endcase
   endfunction

   // watchdog
   initial begin
      #4_000_000;
      checks++; errors++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 0; bus_addr = 0; bus_wr = 0; bus_rd = 0; bus_wdata = 0;
      tmr_ovf = 0; ext_pin = 0; port_in = 0; periph_req = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R8: bits 7..1 cleared
      phase = "R8";
      peek(8'h00, 8'hFE, "R8 reset value");
      cyc(9'h00B, 1, 0, 8'h00, 0);

      // R1 / R7: mirrors and field layout
      phase = "R7";
      cyc(9'h08B, 1, 0, 8'hF8, 0);
      cyc(9'h18B, 0, 1, 8'h00, 0);
      check("R1 layout via 0x18B", last_rd, 8'hF8);
      cyc(9'h00C, 1, 0, 8'h00, 0);
      cyc(9'h10B, 0, 1, 8'h00, 0);
      check("R7 non-hit write ignored", last_rd, 8'hF8);
      cyc(9'h00C, 0, 1, 8'h00, 0);
      check("R7 unmapped read", last_rd, 8'h00);
      cyc(9'h10B, 1, 0, 8'h00, 0);

      // R12 / R2: timer flag with everything masked
      phase = "R12";
      cyc(9'h000, 0, 0, 8'h00, 1);
      peek(8'h04, 8'hFF, "R12 timer flag next edge");
      check("R2 masked flag gives no irq", {7'd0, irq}, 8'h00);
      // R3: hardware holds it, software clears it
      phase = "R3";
      idle(3);
      peek(8'h04, 8'hFF, "R3 flag holds");
      cyc(9'h00B, 1, 0, 8'h00, 0);
      peek(8'h00, 8'hFF, "R3 write clears");
      cyc(9'h00B, 1, 0, 8'h01, 0);
      peek(8'h01, 8'h07, "R3 write of 1 sets");
      cyc(9'h00B, 1, 0, 8'h00, 0);

      // R10: event and clear in the same cycle
      phase = "R10";
      cyc(9'h08B, 1, 0, 8'h00, 1);
      peek(8'h04, 8'hFF, "R10 set beats clear");

      // R6: global gate
      phase = "R6";
      cyc(9'h00B, 1, 0, 8'hA4, 0);
      check("R6 irq with gie", {7'd0, irq}, 8'h01);
      cyc(9'h00B, 1, 0, 8'h24, 0);
      check("R6 gie off", {7'd0, irq}, 8'h00);

      // R9: peripheral gate
      phase = "R9";
      preq_v = 1;
      cyc(9'h00B, 1, 0, 8'h80, 0);
      check("R9 peie off", {7'd0, irq}, 8'h00);
      cyc(9'h00B, 1, 0, 8'hC0, 0);
      check("R9 peie on", {7'd0, irq}, 8'h01);
      cyc(9'h00B, 1, 0, 8'h40, 0);
      check("R9 gie off", {7'd0, irq}, 8'h00);
      preq_v = 0;
      cyc(9'h00B, 1, 0, 8'h00, 0);

      // R11: external pin, two-flop path
      phase = "R11";
      pin_v = 1;
      idle(1);
      peek(8'h00, 8'h02, "R11 edge k");
      peek(8'h00, 8'h02, "R11 edge k+1");
      peek(8'h02, 8'h02, "R11 edge k+2");
      idle(2);
      cyc(9'h00B, 1, 0, 8'h00, 0);
      pin_v = 0;
      idle(4);
      peek(8'h00, 8'h02, "R11 falling edge ignored");

      // R4 / R5: port change
      phase = "R4";
      port_v = 8'h50;
      idle(1);
      peek(8'h01, 8'h07, "R4 mismatch sets flag");
      cyc(9'h00B, 1, 0, 8'h00, 0);
      peek(8'h01, 8'h07, "R4 clear does not stick");
      phase = "R5";
      cyc(9'h106, 0, 1, 8'h00, 0);
      check("R5 port read data", last_rd, 8'h50);
      peek(8'h01, 8'h07, "R5 flag held after read");
      cyc(9'h00B, 1, 0, 8'h00, 0);
      peek(8'h00, 8'h07, "R5 clear sticks");
      phase = "R4";
      port_v = 8'h5F;
      idle(3);
      peek(8'h00, 8'h07, "R4 low nibble ignored");

      // R13 plus overlap soak
      phase = "R13";
      for (int i = 0; i < 600; i++) begin
         int s;
         s = $urandom_range(0, 7);
         if ($urandom_range(0, 5) == 0) pin_v = ~pin_v;
         if ($urandom_range(0, 9) == 0) port_v = 8'($urandom);
         preq_v = ($urandom_range(0, 3) == 0);
         cyc(pick_addr(s), ($urandom_range(0, 2) == 0), $urandom_range(0, 1) == 1,
             8'($urandom), ($urandom_range(0, 6) == 0));
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule